// File: doc/BRIEF.md
# Content-Aware Write Redirection Unit

This unit sits between a requester and a phase-change memory array. Each write word has its set bits counted. Words that are mostly ones are sent to a spare location that already holds all ones, so only RESET programming is needed. Other words go to a location that holds all zeros, so only SET programming is needed. The chosen physical location comes from one of two free pools, and a small fully associative remap table records the new logical-to-physical binding. Reads pass through the same table; a logical address with no entry maps to the physical location with the same index.

The location a logical address used before a redirection goes into a re-initialization queue. It is tagged with the content it should get back: ones when the ones pool is strictly smaller than the zeros pool, zeros otherwise. Background re-initialization writes run only in a cycle with no accepted request, and only to a bank that is idle and has no waiting request. After the write, the location joins the matching pool. When no suitable location can be found, the write falls back to an in-place write whose content is unknown, which needs both programming directions.

Physical addresses are one bit wider than logical ones. The upper half is the spare region: at reset the zeros pool holds spare indices 0..ZERO_INIT-1 and the ones pool holds the next ONE_INIT indices. The bank of a physical address is its low log2(NBANK) bits.

Top module: `cwr_redirect`

## Requirements
- R1: A read is issued to the mapped physical address when the logical address hits in the table, and to {1'b0, logical address} when it misses, with mode 2'b00 and mem_write low.
- R2: A write prefers the ones pool when set_bits*10 >= DATA_W*6 (exactly 60% counts as ones), and the zeros pool otherwise.
- R3: Each command carries a mode: 2'b01 SET-only for a write into a zeros location, 2'b10 RESET-only for a write into a ones location, 2'b11 both directions for an in-place write or a re-initialization.
- R4: If the preferred pool is empty and the other pool is not, the write takes the head of the other pool.
- R5: A write is done in place at its current physical address, with mode 2'b11, when both pools are empty, or when it misses a full table, or when the re-initialization queue is full.
- R6: A redirected write binds its logical address to the new physical location: an existing entry is updated, otherwise a new entry is allocated, and later reads use that binding.
- R7: A redirected write's old location is queued for re-initialization, targeting ones if the ones pool count is strictly below the zeros pool count at that cycle, else zeros. The re-initialization is issued as mem_init=1 with all-zero or all-one data and mode 2'b11, and the location then joins that pool in FIFO order.
- R8: A re-initialization is issued only in a cycle with no accepted request, when its bank is idle and no valid request targets that bank.
- R9: req_ready is high only when the bank of the request's target physical address is idle.
- R10: Commands come out registered, one cycle after acceptance, at most one per cycle; mem_valid is low after reset.
- R11: Free pools and the queue never overflow, because every pop from a pool is matched by a push into the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | LA_W | Logical address |
| req_data | input | DATA_W | Write data |
| bank_idle | input | NBANK | Per-bank idle flags |
| mem_valid | output | 1 | Command valid |
| mem_write | output | 1 | Command is a write |
| mem_init | output | 1 | Command is a background re-initialization |
| mem_mode | output | 2 | Programming mode (R3 encoding) |
| mem_addr | output | LA_W+1 | Physical address |
| mem_data | output | DATA_W | Write data |

## Verification
Assertions check on every cycle that accepted requests and re-initializations only target idle banks and never share a cycle. They also check that a redirection pops exactly one pool, that re-initialization commands carry uniform data and mode 2'b11, that the table never has two hits, and that no FIFO is pushed while full. Only the bench scenarios can show the results that depend on history: the popcount threshold at exactly 60%, the choice of the other pool and the in-place fallbacks, FIFO ordering of recycled locations, the target chosen by pool size, and reads that follow remapped bindings.

// File: rtl/cwr_pkg.sv
package cwr_pkg;
  typedef enum logic [1:0] {
    MODE_READ  = 2'b00,
    MODE_SET   = 2'b01,
    MODE_RESET = 2'b10,
    MODE_BOTH  = 2'b11
  } prog_mode_e;
endpackage

// File: rtl/cwr_fifo.sv
module cwr_fifo #(
  parameter int W         = 8,
  parameter int DEPTH     = 4,
  parameter int INIT_N    = 0,
  parameter int INIT_BASE = 0
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [W-1:0]                   push_data,
  input  logic                           pop,
  output logic [W-1:0]                   head,
  output logic [$clog2(DEPTH+1)-1:0]     count,
  output logic                           empty,
  output logic                           full
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign head  = slots[rd_ptr];
  assign count = cnt_q;
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        slots[i] <= (i < INIT_N) ? W'(INIT_BASE + i) : '0;
      rd_ptr <= '0;
      wr_ptr <= PW'(INIT_N % DEPTH);
      cnt_q  <= CW'(INIT_N);
    end else begin
      if (push) begin
        slots[wr_ptr] <= push_data;
        wr_ptr <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/cwr_map.sv
module cwr_map #(
  parameter int LA_W = 4,
  parameter int PA_W = 5,
  parameter int N    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LA_W-1:0] lk_addr,
  output logic            lk_hit,
  output logic [PA_W-1:0] lk_paddr,
  output logic            tbl_full,
  input  logic            upd_en,
  input  logic [PA_W-1:0] upd_paddr
);
  localparam int FW = $clog2(N+1);

  logic [N-1:0]    ent_valid;
  logic [LA_W-1:0] ent_la [N];
  logic [PA_W-1:0] ent_pa [N];
  logic [N-1:0]    hit_vec;
  logic [FW-1:0]   fill_q;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = ent_valid[g] && (ent_la[g] == lk_addr);
  end

  always_comb begin
    lk_paddr = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) lk_paddr = lk_paddr | ent_pa[i];
  end

  assign lk_hit   = |hit_vec;
  assign tbl_full = (fill_q == FW'(N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      fill_q    <= '0;
      for (int i = 0; i < N; i++) begin
        ent_la[i] <= '0;
        ent_pa[i] <= '0;
      end
    end else if (upd_en) begin
      if (lk_hit) begin
        for (int i = 0; i < N; i++)
          if (hit_vec[i]) ent_pa[i] <= upd_paddr;
      end else if (!tbl_full) begin
        for (int i = 0; i < N; i++)
          if (FW'(i) == fill_q) begin
            ent_valid[i] <= 1'b1;
            ent_la[i]    <= lk_addr;
            ent_pa[i]    <= upd_paddr;
          end
        fill_q <= fill_q + 1'b1;
      end
    end
  end

  assert_single_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  assert_alloc_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !lk_hit) |-> !tbl_full);
endmodule

// File: rtl/cwr_redirect.sv
module cwr_redirect
  import cwr_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int LA_W      = 4,
  parameter int NBANK     = 2,
  parameter int MAP_N     = 4,
  parameter int ZERO_INIT = 2,
  parameter int ONE_INIT  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [LA_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]    req_data,
  input  logic [NBANK-1:0]     bank_idle,
  output logic                 mem_valid,
  output logic                 mem_write,
  output logic                 mem_init,
  output logic [1:0]           mem_mode,
  output logic [LA_W:0]        mem_addr,
  output logic [DATA_W-1:0]    mem_data
);
  localparam int PA_W   = LA_W + 1;
  localparam int SPARE  = ZERO_INIT + ONE_INIT;
  localparam int FIFO_D = (SPARE < 2) ? 2 : SPARE;
  localparam int CNT_W  = $clog2(FIFO_D+1);
  localparam int BANK_W = (NBANK < 2) ? 1 : $clog2(NBANK);
  localparam int SP_BASE = 1 << LA_W;

  function automatic int unsigned set_bits(input logic [DATA_W-1:0] d);
    int unsigned n = 0;
    for (int i = 0; i < DATA_W; i++) n += d[i];
    return n;
  endfunction

  function automatic logic prefers_ones(input logic [DATA_W-1:0] d);
    return (set_bits(d) * 10) >= (DATA_W * 6);
  endfunction

  function automatic logic [BANK_W-1:0] bank_of(input logic [PA_W-1:0] a);
    return a[BANK_W-1:0];
  endfunction

  // translation
  logic            map_hit, map_full;
  logic [PA_W-1:0] map_pa, cur_pa;

  // pools and queue
  logic            z_push, z_pop, z_empty, z_full;
  logic            o_push, o_pop, o_empty, o_full;
  logic [PA_W-1:0] z_head, o_head;
  logic [CNT_W-1:0] z_cnt, o_cnt, q_cnt;
  logic            q_push, q_pop, q_empty, q_full;
  logic [PA_W:0]   q_head, q_in;

  // named events
  logic            want_one, can_redirect, take_z, take_o, redirect;
  logic [PA_W-1:0] new_pa, tgt_pa;
  logic            accept, reinit_fire, pending_same;
  logic            h_ones;
  logic [PA_W-1:0] h_pa;

  cwr_map #(.LA_W(LA_W), .PA_W(PA_W), .N(MAP_N)) u_map (
    .clk(clk), .rst_n(rst_n), .lk_addr(req_addr), .lk_hit(map_hit),
    .lk_paddr(map_pa), .tbl_full(map_full),
    .upd_en(accept && redirect), .upd_paddr(new_pa));

  cwr_fifo #(.W(PA_W), .DEPTH(FIFO_D), .INIT_N(ZERO_INIT), .INIT_BASE(SP_BASE)) u_zpool (
    .clk(clk), .rst_n(rst_n), .push(z_push), .push_data(h_pa), .pop(z_pop),
    .head(z_head), .count(z_cnt), .empty(z_empty), .full(z_full));

  cwr_fifo #(.W(PA_W), .DEPTH(FIFO_D), .INIT_N(ONE_INIT), .INIT_BASE(SP_BASE + ZERO_INIT)) u_opool (
    .clk(clk), .rst_n(rst_n), .push(o_push), .push_data(h_pa), .pop(o_pop),
    .head(o_head), .count(o_cnt), .empty(o_empty), .full(o_full));

  cwr_fifo #(.W(PA_W+1), .DEPTH(FIFO_D), .INIT_N(0), .INIT_BASE(0)) u_reinitq (
    .clk(clk), .rst_n(rst_n), .push(q_push), .push_data(q_in), .pop(q_pop),
    .head(q_head), .count(q_cnt), .empty(q_empty), .full(q_full));

  assign cur_pa   = map_hit ? map_pa : {1'b0, req_addr};
  assign want_one = prefers_ones(req_data);

  assign can_redirect = req_write && (map_hit || !map_full) && !q_full;
  assign take_o = can_redirect && (want_one ? !o_empty : (z_empty && !o_empty));
  assign take_z = can_redirect && (want_one ? (o_empty && !z_empty) : !z_empty);
  assign redirect = take_o || take_z;
  assign new_pa   = take_o ? o_head : z_head;
  assign tgt_pa   = (req_write && redirect) ? new_pa : cur_pa;

  assign req_ready = bank_idle[bank_of(tgt_pa)];
  assign accept    = req_valid && req_ready;

  assign z_pop  = accept && take_z;
  assign o_pop  = accept && take_o;
  assign q_push = accept && redirect;
  assign q_in   = {(o_cnt < z_cnt), cur_pa};

  assign h_ones = q_head[PA_W];
  assign h_pa   = q_head[PA_W-1:0];
  assign pending_same = req_valid && (bank_of(tgt_pa) == bank_of(h_pa));
  assign reinit_fire  = !q_empty && !accept && bank_idle[bank_of(h_pa)] && !pending_same;
  assign q_pop  = reinit_fire;
  assign z_push = reinit_fire && !h_ones;
  assign o_push = reinit_fire && h_ones;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_write <= 1'b0;
      mem_init  <= 1'b0;
      mem_mode  <= MODE_READ;
      mem_addr  <= '0;
      mem_data  <= '0;
    end else begin
      mem_valid <= accept || reinit_fire;
      mem_write <= 1'b0;
      mem_init  <= 1'b0;
      if (accept) begin
        mem_write <= req_write;
        mem_addr  <= tgt_pa;
        mem_data  <= req_data;
        if (!req_write)  mem_mode <= MODE_READ;
        else if (take_z) mem_mode <= MODE_SET;
        else if (take_o) mem_mode <= MODE_RESET;
        else             mem_mode <= MODE_BOTH;
      end else if (reinit_fire) begin
        mem_write <= 1'b1;
        mem_init  <= 1'b1;
        mem_addr  <= h_pa;
        mem_data  <= {DATA_W{h_ones}};
        mem_mode  <= MODE_BOTH;
      end
    end
  end

  assert_accept_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> bank_idle[bank_of(tgt_pa)]);
  assert_reinit_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reinit_fire |-> (bank_idle[bank_of(h_pa)] && !accept));
  assert_one_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(z_pop && z_push) && !(o_pop && o_push));
  assert_one_pool_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && redirect) |-> $onehot({z_pop, o_pop}));
  assert_init_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_init) |-> (mem_mode == MODE_BOTH && mem_write &&
      ($countones(mem_data) == 0 || $countones(mem_data) == DATA_W)));
  assert_cmd_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept || reinit_fire) |=> mem_valid);
endmodule

// File: tb/cwr_redirect_test.sv
module cwr_redirect_test;
  localparam int DW = 10;
  localparam int LW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [LW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [1:0] bank_idle = 2'b11;
  logic req_ready, mem_valid, mem_write, mem_init;
  logic [1:0] mem_mode;
  logic [LW:0] mem_addr;
  logic [DW-1:0] mem_data;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cwr_redirect uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_data(req_data),
    .bank_idle(bank_idle), .mem_valid(mem_valid), .mem_write(mem_write),
    .mem_init(mem_init), .mem_mode(mem_mode), .mem_addr(mem_addr),
    .mem_data(mem_data));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_cmd(input string tag, input logic w, input logic init,
                           input logic [1:0] mode, input int addr, input int data);
    check({tag, " valid"}, 32'(mem_valid), 1);
    check({tag, " write"}, 32'(mem_write), 32'(w));
    check({tag, " init"},  32'(mem_init), 32'(init));
    check({tag, " mode"},  32'(mem_mode), 32'(mode));
    check({tag, " addr"},  32'(mem_addr), 32'(addr));
    if (w) check({tag, " data"}, 32'(mem_data), 32'(data));
  endtask

  // drive at negedge, return at next negedge (one posedge later)
  task automatic issue(input logic w, input int la, input int d);
    req_valid = 1; req_write = w; req_addr = LW'(la); req_data = DW'(d);
    @(negedge clk);
  endtask

  task automatic go_idle();
    req_valid = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 reset mem_valid", 32'(mem_valid), 0);
    check("R9 ready after reset", 32'(req_ready), 1);
  endtask

  task automatic t_read_miss();
    issue(0, 5, 0);
    check_cmd("R1 read miss identity", 0, 0, 2'b00, 5, 0);
    go_idle();
    check("R10 idle no cmd", 32'(mem_valid), 0);
  endtask

  task automatic t_first_writes();
    issue(1, 3, 'h01F);                    // 5 of 10 set -> zeros
    check_cmd("R2 R3 light write to zeros", 1, 0, 2'b01, 16, 'h01F);
    go_idle();
    check_cmd("R7 reinit old loc to zeros", 1, 1, 2'b11, 3, 0);
    issue(0, 3, 0);
    check_cmd("R1 R6 read follows remap", 0, 0, 2'b00, 16, 0);
    issue(1, 7, 'h03F);                    // exactly 60% -> ones
    check_cmd("R2 R3 sixty pct to ones", 1, 0, 2'b10, 18, 'h03F);
    go_idle();
    check_cmd("R7 tie targets zeros", 1, 1, 2'b11, 7, 0);
    issue(1, 9, 'h3FF);
    check_cmd("R2 heavy write", 1, 0, 2'b10, 19, 'h3FF);
    go_idle();
    check_cmd("R7 ones pool smaller", 1, 1, 2'b11, 9, 'h3FF);
    issue(1, 9, 'h3F0);                    // hit, ones pool head is 9
    check_cmd("R7 recycled ones loc", 1, 0, 2'b10, 9, 'h3F0);
    go_idle();
    check_cmd("R6 R7 old mapped loc freed", 1, 1, 2'b11, 19, 'h3FF);
    issue(0, 9, 0);
    check_cmd("R6 remap updated", 0, 0, 2'b00, 9, 0);
    issue(1, 3, 0);
    check_cmd("R6 rewrite hit to zeros", 1, 0, 2'b01, 17, 0);
    go_idle();
    check_cmd("R7 freed loc to ones", 1, 1, 2'b11, 16, 'h3FF);
  endtask

  task automatic t_drain();
    issue(1, 12, 0);
    check_cmd("R6 alloc fourth entry", 1, 0, 2'b01, 3, 0);
    issue(1, 3, 0);
    check_cmd("R2 zeros pool head", 1, 0, 2'b01, 7, 0);
    issue(1, 7, 0);
    check_cmd("R4 other pool used", 1, 0, 2'b10, 19, 0);
    issue(1, 9, 1);
    check_cmd("R4 other pool again", 1, 0, 2'b10, 16, 1);
    issue(1, 9, 2);
    check_cmd("R5 both pools empty in place", 1, 0, 2'b11, 16, 2);
    go_idle();
    check_cmd("R8 reinit after traffic 1", 1, 1, 2'b11, 12, 0);
    @(negedge clk);
    check_cmd("R7 fifo order 2", 1, 1, 2'b11, 17, 0);
    @(negedge clk);
    check_cmd("R7 fifo order 3", 1, 1, 2'b11, 18, 0);
    @(negedge clk);
    check_cmd("R7 fifo order 4", 1, 1, 2'b11, 9, 0);
    @(negedge clk);
    check("R8 queue drained", 32'(mem_valid), 0);
    issue(1, 13, 'h3FF);
    check_cmd("R5 table full miss in place", 1, 0, 2'b11, 13, 'h3FF);
    issue(0, 12, 0);
    check_cmd("R1 read hit full table", 0, 0, 2'b00, 3, 0);
    go_idle();
  endtask

  task automatic t_bank_busy();
    bank_idle = 2'b01;
    req_valid = 1; req_write = 0; req_addr = 5; req_data = 0;
    #1;
    check("R9 ready low busy bank", 32'(req_ready), 0);
    @(negedge clk);
    check("R9 no cmd for busy bank", 32'(mem_valid), 0);
    issue(0, 4, 0);
    check_cmd("R9 idle bank read", 0, 0, 2'b00, 4, 0);
    issue(1, 12, 0);                       // zeros head 12, old loc 3 on busy bank
    check_cmd("R9 write to idle bank", 1, 0, 2'b01, 12, 0);
    go_idle();
    check("R8 reinit held busy 1", 32'(mem_valid), 0);
    @(negedge clk);
    check("R8 reinit held busy 2", 32'(mem_valid), 0);
    bank_idle = 2'b11;
    @(negedge clk);
    check_cmd("R8 R7 reinit once idle", 1, 1, 2'b11, 3, 'h3FF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    @(negedge clk);
    t_read_miss();
    t_first_writes();
    t_drain();
    t_bank_busy();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule